// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives a multi-digit seven-segment display from a held BCD reading, showing one digit per time slot. A transfer strobe copies a fresh reading, together with its overflow bit, into storage. For one cycle after the copy, a data-good output is raised. A slot counter then walks the digits from most significant to least significant and lights one digit enable at a time. The counter steps on a scan tick. That tick comes either from an internal divider or from rising edges of an external scan clock. The choice is made with a synchronous clock-enable on the single system clock.

Zero digits that come before the first nonzero digit of a scan are kept dark. The blank state is re-armed at the start of every scan. The least significant digit is always shown, so a reading of zero displays as a single 0. A stored overflow makes every digit visible. An active-low lamp-test input lights all seven segments while it is held low. A slot-zero indicator goes low in the first slot, and the internal scan tick is also brought out on its own pin.

Top module: `disp_scan_top`

## Requirements
- R1: The slot counter starts at 0 and advances by one on each scan tick, wrapping from NUM_DIGITS-1 to 0. `dig_en` is one-hot with bit k high in slot k. Slot 0 shows the most significant digit (bits [4*NUM_DIGITS-1 -: 4] of `count_bcd`), and slot NUM_DIGITS-1 shows bits [3:0]. `slot0_n` is low only in slot 0.
- R2: While `int_scan_dis_n` is high, the internal divider issues a scan tick once every INT_DIV clocks. `int_scan_out` is high for exactly the one cycle after each internal tick.
- R3: While `int_scan_dis_n` is low, the divider is held and `int_scan_out` stays low. `ext_scan` passes through a two-stage synchroniser, and each of its rising edges gives one scan tick. The slot changes on the third clock edge after `ext_scan` rises.
- R4: A clock edge that samples `xfer` high copies `count_bcd` and `ovf` into storage. `data_good` is high in the following cycle only, and then only if `xfer` was high at that edge.
- R5: Segments are active high, with bit 0 = a through bit 6 = g. Digits 0 to 9 use the standard patterns (0 = 0x3F, 1 = 0x06, 2 = 0x5B, 3 = 0x4F, 4 = 0x66, 5 = 0x6D, 6 = 0x7D, 7 = 0x07, 8 = 0x7F, 9 = 0x6F). Codes 10 to 15 show all segments off.
- R6: Without overflow, a slot's segments are off while its digit is 0 and no earlier slot of the same scan held a nonzero code (codes 10 to 15 count as nonzero). The last slot is never blanked.
- R7: While the stored overflow bit is 1, every slot shows its digit's pattern with no leading-zero blanking.
- R8: While `lamp_n` is low, `seg` is 0x7F in every slot, and the slot scanning continues.
- R9: After synchronous reset (`rst_n` low at a clock edge), the outputs are: slot 0, storage all zero, stored overflow 0, `data_good` 0, `int_scan_out` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_bcd | input | 4*NUM_DIGITS | BCD reading; least significant digit in bits [3:0] |
| xfer | input | 1 | Transfer strobe, copies reading and overflow into storage |
| ovf | input | 1 | Counter overflow bit belonging to the reading |
| lamp_n | input | 1 | Active-low lamp test, lights all segments |
| int_scan_dis_n | input | 1 | Low selects the external scan clock and stops the internal one |
| ext_scan | input | 1 | External scan clock, asynchronous |
| seg | output | 7 | Segment drive a..g, active high |
| dig_en | output | NUM_DIGITS | One-hot digit enable, bit k for slot k |
| slot0_n | output | 1 | Low in slot 0 only |
| data_good | output | 1 | High the cycle after a transfer |
| int_scan_out | output | 1 | One-cycle pulse per internal scan tick |

## Verification
The main function is exercised with several readings: all zeros, leading zeros followed by a nonzero digit, a single nonzero least significant digit, a nonzero most significant digit, and a non-BCD code among zeros. Together these separate blanking that stops at the first nonzero digit from blanking that looks at each digit alone, and they show that the last slot is never dark. The same readings are then repeated with overflow set, and again under lamp test. Finally, the scan source is switched to an external clock with a slow toggle, and transfers are issued in the middle of a scan, so that a slot order which depends on tick timing shows up as a mismatch.

// File: rtl/disp_scan_pkg.sv
// Shared definitions for the display scanner: segment patterns.
// Assumes segment bit 0 = a ... bit 6 = g, active high.
package disp_scan_pkg;

    localparam logic [6:0] SEG_ALL = 7'h7F;
    localparam logic [6:0] SEG_OFF = 7'h00;

    // Convert one BCD code to its seven-segment pattern; non-BCD codes are dark.
    function automatic logic [6:0] bcd_to_seg(input logic [3:0] code);
        logic [6:0] pat;
        case (code)
            4'd0:    pat = 7'h3F;
            4'd1:    pat = 7'h06;
            4'd2:    pat = 7'h5B;
            4'd3:    pat = 7'h4F;
            4'd4:    pat = 7'h66;
            4'd5:    pat = 7'h6D;
            4'd6:    pat = 7'h7D;
            4'd7:    pat = 7'h07;
            4'd8:    pat = 7'h7F;
            4'd9:    pat = 7'h6F;
            default: pat = SEG_OFF;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/scan_clk_sel.sv
// Scan tick source. It produces a one-cycle scan tick either from an
// internal divide-by-INT_DIV counter or from synchronised rising edges of an
// external scan clock. Selection is a synchronous enable; the system clock
// is never gated. Assumes INT_DIV >= 2 and ext_scan asynchronous to clk.
module scan_clk_sel #(
    parameter int INT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_scan_dis_n,
    input  logic ext_scan,
    output logic scan_tick,
    output logic int_scan_out
);
    localparam int DIV_W = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(INT_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             sync1_q, sync2_q, sync3_q;
    logic             int_tick, ext_tick;

    assign int_tick  = int_scan_dis_n && (div_q == DIV_MAX);
    assign ext_tick  = !int_scan_dis_n && sync2_q && !sync3_q;
    assign scan_tick = int_tick || ext_tick;

    // Internal divider: runs while enabled, held at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !int_scan_dis_n)  div_q <= '0;
        else if (div_q == DIV_MAX)      div_q <= '0;
        else                            div_q <= div_q + 1'b1;
    end

    // Synchroniser and edge history for the external scan clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            sync3_q <= 1'b0;
        end else begin
            sync1_q <= ext_scan;
            sync2_q <= sync1_q;
            sync3_q <= sync2_q;
        end
    end

    // Registered copy of the internal tick for the output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) int_scan_out <= 1'b0;
        else        int_scan_out <= int_tick;
    end

    // R3
    int_off_when_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_scan_dis_n |=> !int_scan_out);

    // R2
    int_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_scan_out |=> !int_scan_out);

endmodule

// File: rtl/scan_seq.sv
// Slot sequencer and leading-zero blank flag. The slot advances on each
// scan tick and wraps after the last digit. The blank flag is armed when a
// scan restarts and is cleared by the first nonzero code leaving its slot.
// Assumes cur_zero describes the digit shown in the current slot.
module scan_seq #(
    parameter int NUM_DIGITS = 6,
    localparam int SLOT_W = (NUM_DIGITS > 2) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_tick,
    input  logic              cur_zero,
    output logic [SLOT_W-1:0] slot,
    output logic              blank_arm
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_DIGITS - 1);

    // Step the slot and update the blank flag on each scan tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= '0;
            blank_arm <= 1'b1;
        end else if (scan_tick) begin
            if (slot == LAST) begin
                slot      <= '0;
                blank_arm <= 1'b1;
            end else begin
                slot <= slot + 1'b1;
                if (!cur_zero) blank_arm <= 1'b0;
            end
        end
    end

    // R1
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(slot));

    // R1
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);

    // R6
    blank_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && slot == LAST) |=> blank_arm);

endmodule

// File: rtl/disp_store.sv
// Storage registers for the displayed reading and its overflow bit. A
// transfer strobe copies both in; data_good marks the cycle after the copy.
module disp_store #(
    parameter int NUM_DIGITS = 6,
    localparam int DW = 4 * NUM_DIGITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer,
    input  logic [DW-1:0] count_bcd,
    input  logic          ovf,
    output logic [DW-1:0] store,
    output logic          ovf_q,
    output logic          data_good
);
    // Capture reading and overflow together on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
            ovf_q <= 1'b0;
        end else if (xfer) begin
            store <= count_bcd;
            ovf_q <= ovf;
        end
    end

    // Flag the cycle in which fresh data sits in storage.
    always_ff @(posedge clk) begin
        if (!rst_n) data_good <= 1'b0;
        else        data_good <= xfer;
    end

    // R4
    dg_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (data_good && store == $past(count_bcd)));

    // R4
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> ($stable(store) && !data_good));

endmodule

// File: rtl/disp_scan_top.sv
// Multiplexed seven-segment scanner top. It ties together the tick source,
// the slot sequencer and the storage registers, selects the current digit,
// and applies leading-zero blanking, overflow override and lamp test.
// Assumes one system clock; all other inputs are sampled on it.
module disp_scan_top
    import disp_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 6,
    parameter int INT_DIV    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4*NUM_DIGITS-1:0] count_bcd,
    input  logic                    xfer,
    input  logic                    ovf,
    input  logic                    lamp_n,
    input  logic                    int_scan_dis_n,
    input  logic                    ext_scan,
    output logic [6:0]              seg,
    output logic [NUM_DIGITS-1:0]   dig_en,
    output logic                    slot0_n,
    output logic                    data_good,
    output logic                    int_scan_out
);
    localparam int SLOT_W = (NUM_DIGITS > 2) ? $clog2(NUM_DIGITS) : 1;
    localparam int DW     = 4 * NUM_DIGITS;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_DIGITS - 1);

    logic              scan_tick;
    logic [SLOT_W-1:0] slot;
    logic              blank_arm;
    logic [DW-1:0]     store;
    logic              ovf_q;
    logic [3:0]        cur_digit;
    logic              cur_zero;
    logic              visible;

    scan_clk_sel #(.INT_DIV(INT_DIV)) u_clk_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .int_scan_dis_n (int_scan_dis_n),
        .ext_scan       (ext_scan),
        .scan_tick      (scan_tick),
        .int_scan_out   (int_scan_out)
    );

    scan_seq #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .cur_zero  (cur_zero),
        .slot      (slot),
        .blank_arm (blank_arm)
    );

    disp_store #(.NUM_DIGITS(NUM_DIGITS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .count_bcd (count_bcd),
        .ovf       (ovf),
        .store     (store),
        .ovf_q     (ovf_q),
        .data_good (data_good)
    );

    // Pick the digit for the current slot; slot 0 is the most significant.
    always_comb begin
        cur_digit = 4'd0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (slot == SLOT_W'(i)) cur_digit = store[(NUM_DIGITS-1-i)*4 +: 4];
        end
    end

    // One-hot digit enable derived from the slot number.
    genvar k;
    generate
        for (k = 0; k < NUM_DIGITS; k++) begin : g_den
            assign dig_en[k] = (slot == SLOT_W'(k));
        end
    endgenerate

    assign cur_zero = (cur_digit == 4'd0);
    assign slot0_n  = (slot != '0);
    assign visible  = !blank_arm || !cur_zero || (slot == LAST) || ovf_q;

    // Segment drive: lamp test first, then blanking, then decode.
    always_comb begin
        if (!lamp_n)       seg = SEG_ALL;
        else if (visible)  seg = bcd_to_seg(cur_digit);
        else               seg = SEG_OFF;
    end

    // R8
    lamp_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_n |-> seg == SEG_ALL);

    // R6
    last_never_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_n && dig_en[NUM_DIGITS-1] && cur_digit <= 4'd9) |-> seg != SEG_OFF);

    // R1
    slot0_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot0_n != dig_en[0]);

    // R7
    ovf_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_n && ovf_q && cur_digit == 4'd0) |-> seg == 7'h3F);

endmodule

// File: tb/disp_scan_top_bench.sv
// Bench: a behavioural model steps on every clock edge and is compared
// with the design a quarter period later.
module disp_scan_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ND  = 6;
    localparam int DIV = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4*ND-1:0] count_bcd = '0;
    logic            xfer = 1'b0, ovf = 1'b0, lamp_n = 1'b1;
    logic            int_scan_dis_n = 1'b1, ext_scan = 1'b0;
    logic [6:0]      seg;
    logic [ND-1:0]   dig_en;
    logic            slot0_n, data_good, int_scan_out;

    int compared = 0, mismatched = 0;
    int m_slot, m_blank, m_ovf, m_dg, m_iout, m_div, e1, e2, e3;
    int m_store [ND];
    int post_rst = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_scan_top #(.NUM_DIGITS(ND), .INT_DIV(DIV)) u_disp_scan_top (
        .clk(clk), .rst_n(rst_n), .count_bcd(count_bcd), .xfer(xfer), .ovf(ovf),
        .lamp_n(lamp_n), .int_scan_dis_n(int_scan_dis_n), .ext_scan(ext_scan),
        .seg(seg), .dig_en(dig_en), .slot0_n(slot0_n), .data_good(data_good),
        .int_scan_out(int_scan_out)
    );

    function automatic int seg_pat(int d);
        case (d)
            0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
            4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
            8: return 'h7F; 9: return 'h6F; default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on the edge, then comparison a quarter period later.
    always @(posedge clk) begin
        int cur, itick, etick, exp_seg, vis;
        string stag;
        if (!rst_n) begin
            m_slot = 0; m_blank = 1; m_ovf = 0; m_dg = 0; m_iout = 0; m_div = 0;
            e1 = 0; e2 = 0; e3 = 0; post_rst = 3;
            for (int i = 0; i < ND; i++) m_store[i] = 0;
        end else begin
            cur   = m_store[ND-1-m_slot];
            itick = (int_scan_dis_n && m_div == DIV-1) ? 1 : 0;
            etick = (!int_scan_dis_n && e2 != 0 && e3 == 0) ? 1 : 0;
            if (itick || etick) begin
                if (m_slot == ND-1) begin m_slot = 0; m_blank = 1; end
                else begin
                    if (cur != 0) m_blank = 0;
                    m_slot = m_slot + 1;
                end
            end
            m_iout = itick;
            if (!int_scan_dis_n || m_div == DIV-1) m_div = 0; else m_div = m_div + 1;
            e3 = e2; e2 = e1; e1 = int'(ext_scan);
            m_dg = int'(xfer);
            if (xfer) begin
                for (int i = 0; i < ND; i++) m_store[i] = int'(count_bcd[i*4 +: 4]);
                m_ovf = int'(ovf);
            end
            if (post_rst > 0) post_rst = post_rst - 1;
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            cur = m_store[ND-1-m_slot];
            vis = (!m_blank || cur != 0 || m_slot == ND-1 || m_ovf) ? 1 : 0;
            if (!lamp_n)      begin exp_seg = 'h7F; stag = "R8 lamp test"; end
            else begin
                exp_seg = vis ? seg_pat(cur) : 0;
                if (m_ovf)         stag = "R7 overflow";
                else if (cur > 9)  stag = "R5 decode";
                else               stag = "R6 blanking";
            end
            if (post_rst > 0 || !rst_n) begin
                check("R9 reset slot", int'(dig_en), 1 << m_slot);
                check("R9 reset dg", int'(data_good), m_dg);
                check("R9 reset iout", int'(int_scan_out), m_iout);
            end
            check(stag, int'(seg), exp_seg);
            check(int_scan_dis_n ? "R1 dig_en" : "R3 dig_en ext", int'(dig_en), 1 << m_slot);
            check("R1 slot0_n", int'(slot0_n), (m_slot == 0) ? 0 : 1);
            check("R4 data_good", int'(data_good), m_dg);
            check(int_scan_dis_n ? "R2 int_scan_out" : "R3 int_scan_out", int'(int_scan_out), m_iout);
        end
    end

    task automatic load(logic [4*ND-1:0] v, logic o);
        @(negedge clk);
        count_bcd = v; ovf = o; xfer = 1'b1;
        @(negedge clk);
        xfer = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        run(4);
        // R6: zero reading, leading zeros, lone last digit, leading nonzero
        load(24'h000000, 1'b0); run(60);
        load(24'h001230, 1'b0); run(60);
        load(24'h000007, 1'b0); run(60);
        load(24'h100000, 1'b0); run(60);
        // R5: non-BCD code among zeros
        load(24'h00A050, 1'b0); run(60);
        // R7: overflow shows leading zeros
        load(24'h000012, 1'b1); run(60);
        load(24'h000000, 1'b1); run(30);
        load(24'h098765, 1'b0); run(30);
        // R8: lamp test while scanning
        @(negedge clk) lamp_n = 1'b0; run(30);
        @(negedge clk) lamp_n = 1'b1;
        // R4: transfer in the middle of a scan, back to back
        run(5); load(24'h003400, 1'b0); load(24'h000900, 1'b0); run(40);
        // R3: external scan clock
        @(negedge clk) int_scan_dis_n = 1'b0;
        for (int t = 0; t < 30; t++) begin
            run(3); ext_scan = ~ext_scan;
        end
        load(24'h000560, 1'b0);
        for (int t = 0; t < 30; t++) begin
            run(5); ext_scan = ~ext_scan;
        end
        @(negedge clk) lamp_n = 1'b0; run(10);
        @(negedge clk) lamp_n = 1'b1;
        // R2: back to internal scan
        @(negedge clk) int_scan_dis_n = 1'b1; run(60);
        // R9: reset mid-operation
        @(negedge clk) rst_n = 1'b0; run(2);
        @(negedge clk) rst_n = 1'b1; run(30);
        finish_run();
    end
endmodule